// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives one management transaction at a time on a two-wire PHY management bus, following the clause 22 frame layout. Firmware presents a PHY address, a register address, write data, a clock divider value, a preamble-suppress bit and a two-bit operation code together on one write strobe. If the block is idle and the operation is valid, it latches these values and serialises a frame on the management clock and data lines. On a read it releases the data line for the turnaround and data phases and captures the 16 bits the PHY returns.

The management clock runs only while a frame is in progress and rests low otherwise. Each clock half lasts `div` bus clocks, so one bit takes `2*div` bus clocks. The data line is modelled as three separate signals: output value, output enable and input. A sticky completion flag marks the end of each frame. Writing 1 to its clear strobe clears it.

The controller is a five-state machine. `ST_IDLE` waits for an accepted request. `ST_PRE` sends the preamble ones. `ST_HDR` sends the 14 bits of start delimiter, op code and the two addresses. `ST_TA` covers the two turnaround bits. `ST_DATA` moves the 16 data bits. Transitions:
- `ST_IDLE` goes to `ST_PRE` on an accepted request with the preamble enabled, or to `ST_HDR` with it suppressed.
- `ST_PRE` goes to `ST_HDR` after the 32nd bit.
- `ST_HDR` goes to `ST_TA` after the 14th bit.
- `ST_TA` goes to `ST_DATA` after the 2nd bit.
- `ST_DATA` goes back to `ST_IDLE` after the 16th bit.

Each bit ends on a falling edge of the management clock.

Top module: `mdio_frame_master`

## Requirements
- R1: A request starts a frame only with `cfg_op` = 2'b01 (write) or 2'b10 (read). Codes 2'b00 and 2'b11 leave `busy` low and start nothing.
- R2: A `cfg_wr` made while `busy` is high is ignored entirely. The running frame continues with the op, addresses, data, divider and preamble choice latched at its start, and no second frame follows.
- R3: `busy` rises on the clock edge that accepts a request. It falls on the same edge that sets `done_flag`, after exactly `2*N*div` bus clocks, where N is the frame length in bits.
- R4: With `cfg_nopre` = 0 the frame is 64 bits: 32 ones, then the 32-bit body. With `cfg_nopre` = 1 it is the 32-bit body alone.
- R5: `mdc` is low while idle. During a frame it is low for the first `div` bus clocks of each bit and high for the next `div`, giving a period of `2*div` bus clocks (8 for div = 4).
- R6: A request with `cfg_div` = 0 leaves `busy` low and starts nothing.
- R7: The body is sent MSB first in this order: start bits 0,1; op code (2 bits); PHY address (5 bits); register address (5 bits); turnaround (2 bits); data (16 bits).
- R8: A write drives `mdio_oe` high for the whole frame and sends turnaround bits 1 then 0. A read drives `mdio_oe` high through the header and low for the turnaround and data bits. `mdio_oe` is low while idle.
- R9: `mdio_o` and `mdio_oe` change during a frame only on the edge where `mdc` falls. `mdio_i` is sampled on the edge where `mdc` rises.
- R10: `done_flag` is set when a frame ends and stays set until `done_clr` is pulsed. If a frame ends in the same cycle as `done_clr`, the flag is set.
- R11: `rd_data` is 0 after reset. It takes the 16 sampled bits (first sampled bit as MSB) only when a read frame completes. Write frames leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Request strobe; all cfg_* fields are sampled with it |
| cfg_op | input | 2 | Operation code: 01 write, 10 read |
| cfg_phy | input | 5 | PHY address |
| cfg_reg | input | 5 | Register address inside the PHY |
| cfg_wdata | input | 16 | Data for a write frame |
| cfg_div | input | DIV_W | Half-period length of the management clock, in bus clocks |
| cfg_nopre | input | 1 | 1 suppresses the 32-bit preamble |
| done_clr | input | 1 | Write-1 clear of the completion flag |
| busy | output | 1 | Frame in progress |
| done_flag | output | 1 | Sticky frame-complete flag |
| rd_data | output | 16 | Data captured by the last read frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input from the pad |

## Verification
The bench keeps a behavioural model of the expected bit queue and compares clock, data, enable, busy, flag and read data on every cycle. That comparison catches a header sent LSB first, a dropped or doubled preamble, or a turnaround left driven on a read.

Directed frames measure the busy length with div = 4 (512 and 256 cycles) and the clock period (8 cycles, low half first). A divider that counted `div+1`, or started high, would shift both figures. A conflicting request is sent mid-frame with a different op, divider and preamble setting. A design that relatched any of them would change the frame length or the bit stream.

Requests with op 00, op 11 and a zero divider must leave `busy` low. A write frame after a read must leave the captured data intact, which catches a data register loaded on every frame end.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA
    } mdio_state_t;

    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;

    localparam int PRE_BITS  = 32;
    localparam int HDR_BITS  = 14;
    localparam int TA_BITS   = 2;
    localparam int DATA_BITS = 16;
    localparam int ADDR_BITS = 5;

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_evt,
    output logic             fall_evt
);

    logic [DIV_W-1:0] cnt;
    logic             half_end;

    assign half_end = run && (cnt == div - DIV_W'(1));
    assign rise_evt = half_end && !mdc;
    assign fall_evt = half_end && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (half_end) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    // R5: a half period never runs past the latched divider
    p_half_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < div));

    // R5: the clock rests low whenever no frame runs
    p_rest_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [1:0]           cfg_op,
    input  logic [ADDR_BITS-1:0] cfg_phy,
    input  logic [ADDR_BITS-1:0] cfg_reg,
    input  logic [DATA_BITS-1:0] cfg_wdata,
    input  logic [DIV_W-1:0]     cfg_div,
    input  logic                 cfg_nopre,
    input  logic                 rise_evt,
    input  logic                 fall_evt,
    input  logic                 mdio_i,
    output logic                 busy,
    output logic                 run,
    output logic [DIV_W-1:0]     div_q,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 frame_end,
    output logic                 is_read,
    output logic [DATA_BITS-1:0] rd_word
);

    localparam int CNT_W = $clog2(PRE_BITS);

    mdio_state_t          state, nxt;
    logic [CNT_W-1:0]     bit_cnt;
    logic [1:0]           op_q;
    logic [ADDR_BITS-1:0] phy_q, reg_q;
    logic [DATA_BITS-1:0] wdata_q;
    logic                 start, last_bit;
    logic [HDR_BITS-1:0]  hdr_word;
    logic [3:0]           hdr_idx, dat_idx;

    assign start = cfg_wr && (state == ST_IDLE)
                   && ((cfg_op == OP_WRITE) || (cfg_op == OP_READ))
                   && (cfg_div != '0);

    assign busy      = (state != ST_IDLE);
    assign run       = busy;
    assign is_read   = (op_q == OP_READ);
    assign hdr_word  = {2'b01, op_q, phy_q, reg_q};
    assign hdr_idx   = 4'(HDR_BITS - 1) - bit_cnt[3:0];
    assign dat_idx   = 4'(DATA_BITS - 1) - bit_cnt[3:0];
    assign frame_end = (state == ST_DATA) && last_bit;

    // last bit of the current state, ended by a falling clock edge
    always_comb begin
        last_bit = 1'b0;
        unique case (state)
            ST_IDLE: last_bit = 1'b0;
            ST_PRE:  last_bit = fall_evt && (bit_cnt == CNT_W'(PRE_BITS - 1));
            ST_HDR:  last_bit = fall_evt && (bit_cnt == CNT_W'(HDR_BITS - 1));
            ST_TA:   last_bit = fall_evt && (bit_cnt == CNT_W'(TA_BITS - 1));
            ST_DATA: last_bit = fall_evt && (bit_cnt == CNT_W'(DATA_BITS - 1));
            default: last_bit = 1'b0;
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start)    nxt = cfg_nopre ? ST_HDR : ST_PRE;
            ST_PRE:  if (last_bit) nxt = ST_HDR;
            ST_HDR:  if (last_bit) nxt = ST_TA;
            ST_TA:   if (last_bit) nxt = ST_DATA;
            ST_DATA: if (last_bit) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register, bit counter and request latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            op_q    <= '0;
            phy_q   <= '0;
            reg_q   <= '0;
            wdata_q <= '0;
            div_q   <= '0;
            rd_word <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) begin
                bit_cnt <= '0;
            end else if (fall_evt) begin
                bit_cnt <= bit_cnt + CNT_W'(1);
            end
            if (start) begin
                op_q    <= cfg_op;
                phy_q   <= cfg_phy;
                reg_q   <= cfg_reg;
                wdata_q <= cfg_wdata;
                div_q   <= cfg_div;
            end
            if (rise_evt && (state == ST_DATA) && is_read) begin
                rd_word <= {rd_word[DATA_BITS-2:0], mdio_i};
            end
        end
    end

    // line outputs, decoded from the state
    always_comb begin
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        unique case (state)
            ST_IDLE: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
            ST_PRE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_HDR: begin
                mdio_o  = hdr_word[hdr_idx];
                mdio_oe = 1'b1;
            end
            ST_TA: begin
                mdio_o  = !is_read && (bit_cnt == '0);
                mdio_oe = !is_read;
            end
            ST_DATA: begin
                mdio_o  = !is_read && wdata_q[dat_idx];
                mdio_oe = !is_read;
            end
            default: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
        endcase
    end

    // R2: a request during a frame leaves every latched field alone
    p_busy_wr_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cfg_wr |=> $stable(div_q) && $stable(op_q) && $stable(wdata_q)
                            && $stable(phy_q) && $stable(reg_q));

    // R8: a read releases the line for turnaround and data
    p_read_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_TA) || (state == ST_DATA)) && is_read |-> !mdio_oe);

    // R4: preamble is entered only when a frame starts
    p_pre_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE) && !$past(state == ST_PRE) |-> $past(state == ST_IDLE));

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [1:0]           cfg_op,
    input  logic [ADDR_BITS-1:0] cfg_phy,
    input  logic [ADDR_BITS-1:0] cfg_reg,
    input  logic [DATA_BITS-1:0] cfg_wdata,
    input  logic [DIV_W-1:0]     cfg_div,
    input  logic                 cfg_nopre,
    input  logic                 done_clr,
    output logic                 busy,
    output logic                 done_flag,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 mdc,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    input  logic                 mdio_i
);

    logic                 run, rise_evt, fall_evt, frame_end, is_read;
    logic [DIV_W-1:0]     div_q;
    logic [DATA_BITS-1:0] rd_word;

    mdio_clkdiv #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div      (div_q),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_frame_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_op    (cfg_op),
        .cfg_phy   (cfg_phy),
        .cfg_reg   (cfg_reg),
        .cfg_wdata (cfg_wdata),
        .cfg_div   (cfg_div),
        .cfg_nopre (cfg_nopre),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .run       (run),
        .div_q     (div_q),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .frame_end (frame_end),
        .is_read   (is_read),
        .rd_word   (rd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            rd_data   <= '0;
        end else begin
            if (frame_end) begin
                done_flag <= 1'b1;
            end else if (done_clr) begin
                done_flag <= 1'b0;
            end
            if (frame_end && is_read) begin
                rd_data <= rd_word;
            end
        end
    end

    // R5: no clock while idle
    p_mdc_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R1: unused op codes start nothing
    p_bad_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && !busy && ((cfg_op == 2'b00) || (cfg_op == 2'b11)) |=> !busy);

    // R6: a zero divider starts nothing
    p_zero_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && !busy && (cfg_div == '0) |=> !busy);

    // R3: busy drops exactly as the flag appears
    p_busy_end_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag && !$past(done_flag && !done_clr && busy && !frame_end));

    // R9: line changes only with a falling clock inside a frame
    p_line_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && !$fell(mdc) |-> $stable(mdio_o) && $stable(mdio_oe));

    // R11: read data moves only at the end of a read frame
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_end && is_read) |=> $stable(rd_data));

endmodule

// File: tb/tb_mdio_frame_master.sv
`timescale 1ns/1ps
module tb_mdio_frame_master;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [1:0]  cfg_op;
    logic [4:0]  cfg_phy, cfg_reg;
    logic [15:0] cfg_wdata;
    logic [7:0]  cfg_div;
    logic        cfg_nopre, done_clr, mdio_i;
    logic        busy, done_flag, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // reference model state
    bit        m_busy = 0, m_done = 0, m_read = 0;
    int        m_k = 0, m_div = 1, m_n = 0, m_pre = 0;
    bit        m_bits[$];
    bit        m_oe[$];
    logic [15:0] m_rd = '0;
    logic [15:0] phy_val = '0;

    always #10 clk = ~clk;

    mdio_frame_master dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_op(cfg_op),
        .cfg_phy(cfg_phy), .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata),
        .cfg_div(cfg_div), .cfg_nopre(cfg_nopre), .done_clr(done_clr),
        .busy(busy), .done_flag(done_flag), .rd_data(rd_data), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // model update on the bus clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_k = 0; m_rd = '0;
        end else begin
            bit set_now;
            set_now = 0;
            if (m_busy) begin
                m_k++;
                if (m_k == 2 * m_n * m_div) begin
                    m_busy = 0;
                    set_now = 1;
                    if (m_read) m_rd = phy_val;
                end
            end else if (cfg_wr && (cfg_op == 2'b01 || cfg_op == 2'b10) && cfg_div != 0) begin
                m_busy = 1; m_k = 0; m_div = int'(cfg_div);
                m_read = (cfg_op == 2'b10);
                m_pre  = cfg_nopre ? 0 : 32;
                m_bits.delete(); m_oe.delete();
                for (int i = 0; i < m_pre; i++) begin m_bits.push_back(1); m_oe.push_back(1); end
                m_bits.push_back(0); m_oe.push_back(1);
                m_bits.push_back(1); m_oe.push_back(1);
                for (int i = 1; i >= 0; i--) begin m_bits.push_back(cfg_op[i]); m_oe.push_back(1); end
                for (int i = 4; i >= 0; i--) begin m_bits.push_back(cfg_phy[i]); m_oe.push_back(1); end
                for (int i = 4; i >= 0; i--) begin m_bits.push_back(cfg_reg[i]); m_oe.push_back(1); end
                m_bits.push_back(1); m_oe.push_back(!m_read);
                m_bits.push_back(0); m_oe.push_back(!m_read);
                for (int i = 15; i >= 0; i--) begin m_bits.push_back(cfg_wdata[i]); m_oe.push_back(!m_read); end
                m_n = m_bits.size();
            end
            if (set_now) m_done = 1;
            else if (done_clr) m_done = 0;
        end
    end

    // PHY response and per-cycle comparison away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            report();
        end
        mdio_i = 1'b1;
        if (m_busy && m_read) begin
            int d;
            d = m_k / (2 * m_div) - m_pre - 16;
            if (d >= 0 && d < 16) mdio_i = phy_val[15 - d];
        end
        if (rst_n) begin
            check("R3 busy", busy, m_busy);
            check("R5 mdc", mdc, m_busy ? ((m_k / m_div) % 2) : 0);
            check("R10 done_flag", done_flag, m_done);
            check("R11 rd_data", rd_data, m_rd);
            if (m_busy) begin
                int b;
                b = m_k / (2 * m_div);
                check("R8 mdio_oe", mdio_oe, m_oe[b]);
                if (m_oe[b]) check("R7 mdio_o", mdio_o, m_bits[b]);
            end else begin
                check("R8 mdio_oe idle", mdio_oe, 0);
            end
        end
    end

    task automatic request(input logic [1:0] op, input logic [7:0] dv, input bit np,
                           input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
        @(negedge clk);
        cfg_op = op; cfg_div = dv; cfg_nopre = np;
        cfg_phy = pa; cfg_reg = ra; cfg_wdata = wd; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // count busy cycles and first two mdc rises; optionally inject a request mid-frame
    task automatic measure(input bit inject, output int len, output int r1, output int r2);
        bit prev;
        len = 0; r1 = -1; r2 = -1; prev = 0;
        while (busy && len < 20000) begin
            if (mdc && !prev) begin
                if (r1 < 0) r1 = len;
                else if (r2 < 0) r2 = len;
            end
            prev = mdc;
            if (inject && len == 20) begin
                cfg_op = 2'b10; cfg_div = 8'd2; cfg_nopre = 1'b1;
                cfg_phy = 5'h03; cfg_reg = 5'h1F; cfg_wdata = 16'h0000; cfg_wr = 1'b1;
            end
            if (len == 21) cfg_wr = 1'b0;
            len++;
            @(negedge clk);
        end
    endtask

    initial begin
        int len, r1, r2;
        rst_n = 1'b0; cfg_wr = 0; cfg_op = 0; cfg_phy = 0; cfg_reg = 0;
        cfg_wdata = 0; cfg_div = 0; cfg_nopre = 0; done_clr = 0;
        repeat (3) @(negedge clk);
        check("R3 reset busy", busy, 0);
        check("R5 reset mdc", mdc, 0);
        check("R8 reset oe", mdio_oe, 0);
        check("R10 reset flag", done_flag, 0);
        check("R11 reset rd_data", rd_data, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // write with preamble, div 4, conflicting request mid-frame
        request(2'b01, 8'd4, 1'b0, 5'h11, 5'h0A, 16'hA53C);
        measure(1'b1, len, r1, r2);
        check("R4 frame length with preamble", len, 512);
        check("R2 no second frame", busy, 0);
        check("R5 first rise after low half", r1, 4);
        check("R5 mdc period", r2 - r1, 8);
        check("R10 flag set after write", done_flag, 1);
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
        check("R10 flag cleared", done_flag, 0);

        // read without preamble
        phy_val = 16'h5AC3;
        request(2'b10, 8'd4, 1'b1, 5'h02, 5'h01, 16'h0000);
        measure(1'b0, len, r1, r2);
        check("R4 frame length without preamble", len, 256);
        check("R11 read data captured", rd_data, 16'h5AC3);

        // requests that must start nothing
        request(2'b00, 8'd4, 1'b0, 5'h01, 5'h01, 16'h1111);
        check("R1 op 00 ignored", busy, 0);
        request(2'b11, 8'd4, 1'b0, 5'h01, 5'h01, 16'h1111);
        check("R1 op 11 ignored", busy, 0);
        request(2'b01, 8'd0, 1'b0, 5'h01, 5'h01, 16'h1111);
        check("R6 zero divider ignored", busy, 0);

        // fast write leaves read data alone
        request(2'b01, 8'd1, 1'b1, 5'h1F, 5'h10, 16'hFFFF);
        measure(1'b0, len, r1, r2);
        check("R5 div 1 frame length", len, 64);
        check("R11 write keeps rd_data", rd_data, 16'h5AC3);

        // read with preamble, odd divider, clear held across the end
        phy_val = 16'h8001;
        request(2'b10, 8'd3, 1'b0, 5'h15, 5'h0E, 16'h0000);
        done_clr = 1'b1;
        measure(1'b0, len, r1, r2);
        check("R3 busy length div 3", len, 384);
        check("R10 set wins over clear", done_flag, 1);
        @(negedge clk);
        check("R10 clear after set", done_flag, 0);
        done_clr = 1'b0;
        check("R11 second read", rd_data, 16'h8001);

        repeat (4) @(negedge clk);
        report();
    end

endmodule